// File: doc/BRIEF.md
# Multi-Mode Video Pixel Output Formatter

This block sits at the end of a video processing pipeline. Each cycle in which `pix_valid` is high it accepts one processed pixel. The three component inputs carry luma and both chroma samples in the 4:2:2 modes, and green, blue and red in the RGB mode. It lays that pixel onto a 20-bit pixel port, `pix_out[19:0]`, in the format picked by a mode code. Pin `pix_out[k]` stands for port pin Pk.

Alongside the data it drives a per-pin output-enable vector, `pix_oe`. An enable bit of 0 marks that pin as high-impedance for the pad ring. Every pin whose enable bit is 0 also carries 0 on `pix_out`.

The formats are:
- a single-lane stream of 8 or 10 bits that interleaves chroma and luma;
- a two-lane stream of 16 or 20 bits with luma and chroma on separate lanes;
- a 12-bit double-data-rate RGB stream in which each pixel is split into two halves, one per clock phase.

The clock phase is modelled by the `ddr_phase` input.

A new mode code is taken only at a line-start strobe. The same strobe restarts the chroma alternation, so every line begins on Cb.

Top module: `pix_out_fmt`

## Requirements
- R1: While `rst_n` is low, and after reset until the first line-start strobe, `pix_oe` is all zeros and `pix_out` is all zeros.
- R2: Mode codes are 0 = 8-bit interleaved, 1 = 10-bit interleaved, 2 = 16-bit two-lane, 3 = 20-bit two-lane and 4 = 12-bit DDR RGB. `mode_req` is taken only in a cycle with `line_start` high, and the new enable vector appears in the next cycle. Changing `mode_req` without a line-start strobe leaves `pix_oe` unchanged.
- R3: In mode 3, one cycle after a pixel is accepted, luma bits 9..0 appear on P19..P10 and the current chroma bits 9..0 appear on P9..P0. All 20 pins are enabled.
- R4: In mode 2, the upper 8 bits of luma appear on P19..P12 and the upper 8 bits of chroma appear on P9..P2, one cycle after acceptance. P11, P10, P1 and P0 are disabled.
- R5: In mode 0, the upper 8 bits of each slot appear on P19..P12. Only P19..P12 are enabled.
- R6: In mode 1, the full 10-bit slot appears on P19..P10. Only P19..P10 are enabled.
- R7: In modes 0 and 1, each accepted pixel takes two slots. Its chroma appears in the cycle after acceptance and its luma in the cycle after that, so a line reads Cb, Y, Cr, Y. Pixels are accepted at most every other cycle.
- R8: In modes 0 to 3, the first pixel after a line-start strobe carries Cb. Later pixels alternate Cr, Cb, and so on.
- R9: In mode 4 with `ddr_phase` high, blue[9:2] appears on P19..P12 and green[5:2] appears on P9..P6.
- R10: In mode 4 with `ddr_phase` low, red[5:2] appears on P19..P16, green[9:6] on P15..P12 and red[9:6] on P9..P6.
- R11: In mode 4, both halves come from the last accepted pixel and are held until the next pixel is accepted. P11, P10 and P5..P0 are disabled.
- R12: Mode codes 5, 6 and 7 disable every pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_start | input | 1 | One-cycle strobe before the first pixel of a line |
| mode_req | input | 3 | Requested output mode code |
| pix_valid | input | 1 | Pixel on the component inputs is accepted this cycle |
| y_g_in | input | 10 | Luma, or green in RGB mode |
| cb_b_in | input | 10 | Cb, or blue in RGB mode |
| cr_r_in | input | 10 | Cr, or red in RGB mode |
| ddr_phase | input | 1 | DDR half select: high = first half, low = second half |
| pix_out | output | 20 | Pixel port P19..P0 |
| pix_oe | output | 20 | Per-pin output enable, 0 = high-impedance |

## Verification
The assertions rely on three properties of the input stream:
- `line_start` is never high in the same cycle as `pix_valid`;
- in the interleaved modes a pixel is never offered in the cycle right after another;
- `line_start` stays low while reset is applied.

The bench keeps to all three. Its driver raises the line-start strobe only in its own cycle, always inserts an idle cycle after each interleaved pixel, and holds the strobe low for the whole reset period. DDR checks change `ddr_phase` only between pixels. This lets the hold properties treat any change on the port as coming from a new pixel or a phase flip.

// File: rtl/pof_pkg.sv
// Package: shared widths, mode codes and the per-mode pin enable mask.
// Assumes the port is two lanes of COMP_W bits each.
package pof_pkg;
    localparam int COMP_W   = 10;
    localparam int PORT_W   = 2 * COMP_W;
    localparam int LANE_W   = PORT_W / 2;
    localparam int NARROW_W = 8;
    localparam int NIB_W    = NARROW_W / 2;

    localparam logic [2:0] MODE_IL8   = 3'd0;
    localparam logic [2:0] MODE_IL10  = 3'd1;
    localparam logic [2:0] MODE_TL16  = 3'd2;
    localparam logic [2:0] MODE_TL20  = 3'd3;
    localparam logic [2:0] MODE_DDR12 = 3'd4;
    localparam logic [2:0] MODE_OFF   = 3'd7;

    // Pins driven in a given mode; unknown codes drive nothing.
    function automatic logic [PORT_W-1:0] pin_mask(input logic [2:0] m);
        logic [PORT_W-1:0] k;
        k = '0;
        case (m)
            MODE_IL8:   k[PORT_W-1 -: NARROW_W] = '1;
            MODE_IL10:  k[PORT_W-1 -: COMP_W]   = '1;
            MODE_TL16: begin
                k[PORT_W-1 -: NARROW_W] = '1;
                k[LANE_W-1 -: NARROW_W] = '1;
            end
            MODE_TL20:  k = '1;
            MODE_DDR12: begin
                k[PORT_W-1 -: NARROW_W] = '1;
                k[LANE_W-1 -: NIB_W]    = '1;
            end
            default:    k = '0;
        endcase
        return k;
    endfunction
endpackage

// File: rtl/pof_mode_seq.sv
// Mode and line sequencer: holds the active mode code and the chroma
// parity of the current line. Assumes line_start never coincides with
// pix_valid.
module pof_mode_seq
    import pof_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_start,
    input  logic [2:0] mode_req,
    input  logic       pix_valid,
    output logic [2:0] mode_q,
    output logic       chroma_odd
);
    // Active mode: loaded only at a line boundary, reset to all-off.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_OFF;
        else if (line_start)
            mode_q <= mode_req;
    end

    // Chroma parity: restarts on Cb each line, flips per accepted pixel.
    always_ff @(posedge clk) begin
        if (!rst_n || line_start)
            chroma_odd <= 1'b0;
        else if (pix_valid)
            chroma_odd <= ~chroma_odd;
    end
endmodule

// File: rtl/pof_lane_map.sv
// Lane mapper: places the components of one pixel into the two port
// words. word_a is the first slot or first DDR half, word_b the second.
// Two-lane modes use word_a only. Pins not driven by a mode stay zero.
module pof_lane_map
    import pof_pkg::*;
(
    input  logic [2:0]        mode,
    input  logic              chroma_odd,
    input  logic [COMP_W-1:0] y_g,
    input  logic [COMP_W-1:0] cb_b,
    input  logic [COMP_W-1:0] cr_r,
    output logic [PORT_W-1:0] word_a,
    output logic [PORT_W-1:0] word_b
);
    logic [COMP_W-1:0]   chroma;
    logic [NARROW_W-1:0] y_n, c_n, b_n, r_n;

    assign chroma = chroma_odd ? cr_r : cb_b;
    assign y_n    = y_g[COMP_W-1 -: NARROW_W];
    assign c_n    = chroma[COMP_W-1 -: NARROW_W];
    assign b_n    = cb_b[COMP_W-1 -: NARROW_W];
    assign r_n    = cr_r[COMP_W-1 -: NARROW_W];

    // Field placement per mode.
    always_comb begin
        word_a = '0;
        word_b = '0;
        case (mode)
            MODE_IL8: begin
                word_a[PORT_W-1 -: NARROW_W] = c_n;
                word_b[PORT_W-1 -: NARROW_W] = y_n;
            end
            MODE_IL10: begin
                word_a[PORT_W-1 -: COMP_W] = chroma;
                word_b[PORT_W-1 -: COMP_W] = y_g;
            end
            MODE_TL16: begin
                word_a[PORT_W-1 -: NARROW_W] = y_n;
                word_a[LANE_W-1 -: NARROW_W] = c_n;
            end
            MODE_TL20: begin
                word_a[PORT_W-1 -: COMP_W] = y_g;
                word_a[LANE_W-1 -: COMP_W] = chroma;
            end
            MODE_DDR12: begin
                word_a[PORT_W-1 -: NARROW_W]      = b_n;
                word_a[LANE_W-1 -: NIB_W]         = y_n[NIB_W-1:0];
                word_b[PORT_W-1 -: NIB_W]         = r_n[NIB_W-1:0];
                word_b[PORT_W-NIB_W-1 -: NIB_W]   = y_n[NARROW_W-1 -: NIB_W];
                word_b[LANE_W-1 -: NIB_W]         = r_n[NARROW_W-1 -: NIB_W];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pof_out_stage.sv
// Output stage: registers both words of the accepted pixel together and
// picks the word shown on the port: slot order in the interleaved modes,
// ddr_phase in DDR mode, the first word otherwise. Assumes at most one
// interleaved pixel every two cycles.
module pof_out_stage
    import pof_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode,
    input  logic              pix_valid,
    input  logic              ddr_phase,
    input  logic [PORT_W-1:0] word_a,
    input  logic [PORT_W-1:0] word_b,
    output logic [PORT_W-1:0] pins_raw
);
    logic [PORT_W-1:0] half_a, half_b;
    logic              slot_b;
    logic              is_il;

    assign is_il = (mode == MODE_IL8) || (mode == MODE_IL10);

    // Capture both halves of one pixel in the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_a <= '0;
            half_b <= '0;
        end else if (pix_valid) begin
            half_a <= word_a;
            half_b <= word_b;
        end
    end

    // Slot tracker: first slot after capture, second slot afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n || pix_valid)
            slot_b <= 1'b0;
        else
            slot_b <= is_il;
    end

    // Port word select per mode.
    always_comb begin
        if (mode == MODE_DDR12)
            pins_raw = ddr_phase ? half_a : half_b;
        else if (is_il)
            pins_raw = slot_b ? half_b : half_a;
        else
            pins_raw = half_a;
    end
endmodule

// File: rtl/pix_out_fmt.sv
// Top: multi-mode pixel output formatter. Ties the sequencer, the lane
// mapper and the output stage together, and drives the enable vector.
// Disabled pins are forced to zero.
module pix_out_fmt
    import pof_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic [2:0]        mode_req,
    input  logic              pix_valid,
    input  logic [COMP_W-1:0] y_g_in,
    input  logic [COMP_W-1:0] cb_b_in,
    input  logic [COMP_W-1:0] cr_r_in,
    input  logic              ddr_phase,
    output logic [PORT_W-1:0] pix_out,
    output logic [PORT_W-1:0] pix_oe
);
    logic [2:0]        mode_q;
    logic              chroma_odd;
    logic [PORT_W-1:0] word_a, word_b, pins_raw;

    pof_mode_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .mode_req   (mode_req),
        .pix_valid  (pix_valid),
        .mode_q     (mode_q),
        .chroma_odd (chroma_odd)
    );

    pof_lane_map u_map (
        .mode       (mode_q),
        .chroma_odd (chroma_odd),
        .y_g        (y_g_in),
        .cb_b       (cb_b_in),
        .cr_r       (cr_r_in),
        .word_a     (word_a),
        .word_b     (word_b)
    );

    pof_out_stage u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_q),
        .pix_valid  (pix_valid),
        .ddr_phase  (ddr_phase),
        .word_a     (word_a),
        .word_b     (word_b),
        .pins_raw   (pins_raw)
    );

    // Enable vector: nothing is driven while reset is asserted.
    assign pix_oe  = rst_n ? pin_mask(mode_q) : '0;
    assign pix_out = pins_raw & pix_oe;
endmodule

// File: rtl/pof_checker.sv
// Checker for pix_out_fmt, bound to every instance. Assumes line_start is
// low during reset and never coincides with pix_valid.
module pof_checker
    import pof_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              line_start,
    input logic              pix_valid,
    input logic              ddr_phase,
    input logic              chroma_odd,
    input logic [PORT_W-1:0] pix_out,
    input logic [PORT_W-1:0] pix_oe
);
    logic two_lane, ddr;
    assign two_lane = (pix_oe == pin_mask(MODE_TL16)) || (pix_oe == pin_mask(MODE_TL20));
    assign ddr      = (pix_oe == pin_mask(MODE_DDR12));

    // R1: reset disables every pin.
    always @(negedge clk) begin
        if (!rst_n)
            assert_reset_oe_R1: assert (pix_oe == '0) else $error("oe active in reset");
    end

    assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(line_start) |-> $stable(pix_oe));

    assert_legal_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_oe == '0) || (pix_oe == pin_mask(MODE_IL8)) || (pix_oe == pin_mask(MODE_IL10))
        || two_lane || ddr);

    assert_cb_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !chroma_odd);

    assert_chroma_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !line_start) |=> (chroma_odd != $past(chroma_odd)));

    assert_two_lane_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (two_lane && !pix_valid && !line_start) |=> $stable(pix_out));

    assert_ddr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ddr && !pix_valid && !line_start) |=> (!$stable(ddr_phase) || $stable(pix_out)));
endmodule

bind pix_out_fmt pof_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .pix_valid  (pix_valid),
    .ddr_phase  (ddr_phase),
    .chroma_odd (chroma_odd),
    .pix_out    (pix_out),
    .pix_oe     (pix_oe)
);

// File: tb/pix_out_fmt_tb.sv
// Scoreboard bench: driver tasks queue cycle-stamped expectations and a
// monitor compares them at the falling edge of the stamped cycle.
module pix_out_fmt_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0, line_start = 1'b0, pix_valid = 1'b0, ddr_phase = 1'b1;
    logic [2:0]  mode_req = 3'd0;
    logic [9:0]  yv = '0, cbv = '0, crv = '0;
    logic [19:0] pins, oe;

    pix_out_fmt u_dut (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .mode_req(mode_req),
        .pix_valid(pix_valid), .y_g_in(yv), .cb_b_in(cbv), .cr_r_in(crv),
        .ddr_phase(ddr_phase), .pix_out(pins), .pix_oe(oe)
    );

    typedef struct {
        int          at;
        logic [19:0] pins;
        logic [19:0] oe;
        bit          chk_pins;
        string       rq;
    } exp_t;

    exp_t q[$];
    int   cyc = 0, n_run = 0, n_fail = 0, cur_mode = 7;
    bit   odd = 1'b0, done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [19:0] bmask(input int m);
        case (m)
            0: return 20'hFF000;
            1: return 20'hFFC00;
            2: return 20'hFF3FC;
            3: return 20'hFFFFF;
            4: return 20'hFF3C0;
            default: return 20'h00000;
        endcase
    endfunction

    function automatic logic [19:0] bword(input int m, input bit second,
            input logic [9:0] y, input logic [9:0] cb, input logic [9:0] cr, input bit o);
        logic [9:0] ch;
        ch = o ? cr : cb;
        case (m)
            0: return second ? {y[9:2], 12'h0} : {ch[9:2], 12'h0};
            1: return second ? {y, 10'h0} : {ch, 10'h0};
            2: return {y[9:2], 2'b00, ch[9:2], 2'b00};
            3: return {y, ch};
            4: return second ? {cr[5:2], y[9:6], 2'b00, cr[9:6], 6'h0}
                             : {cb[9:2], 2'b00, y[5:2], 6'h0};
            default: return 20'h0;
        endcase
    endfunction

    task automatic push(input int at, input logic [19:0] p, input logic [19:0] o,
                        input bit cp, input string rq);
        exp_t e;
        e.at = at; e.pins = p; e.oe = o; e.chk_pins = cp; e.rq = rq;
        q.push_back(e);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic new_line(input int m, input string rq);
        line_start = 1'b1;
        mode_req   = m[2:0];
        push(cyc + 1, 20'h0, bmask(m), 1'b0, rq);
        step();
        line_start = 1'b0;
        cur_mode   = m;
        odd        = 1'b0;
    endtask

    task automatic pix(input logic [9:0] y, input logic [9:0] cb, input logic [9:0] cr,
                       input string rq);
        yv = y; cbv = cb; crv = cr;
        pix_valid = 1'b1;
        if (cur_mode <= 1) begin
            push(cyc + 1, bword(cur_mode, 1'b0, y, cb, cr, odd), bmask(cur_mode), 1'b1, rq);
            push(cyc + 2, bword(cur_mode, 1'b1, y, cb, cr, odd), bmask(cur_mode), 1'b1, "R7");
        end else if (cur_mode <= 3) begin
            push(cyc + 1, bword(cur_mode, 1'b0, y, cb, cr, odd), bmask(cur_mode), 1'b1, rq);
        end
        step();
        pix_valid = 1'b0;
        odd = ~odd;
        if (cur_mode <= 1) step();
    endtask

    task automatic ddr_pix(input logic [9:0] y, input logic [9:0] cb, input logic [9:0] cr);
        pix(y, cb, cr, "R11");
        ddr_phase = 1'b1;
        push(cyc, bword(4, 1'b0, y, cb, cr, 1'b0), bmask(4), 1'b1, "R9");
        step();
        ddr_phase = 1'b0;
        push(cyc, bword(4, 1'b1, y, cb, cr, 1'b0), bmask(4), 1'b1, "R10");
        step();
        ddr_phase = 1'b1;
        push(cyc, bword(4, 1'b0, y, cb, cr, 1'b0), bmask(4), 1'b1, "R11");
        step();
        ddr_phase = 1'b0;
        push(cyc, bword(4, 1'b1, y, cb, cr, 1'b0), bmask(4), 1'b1, "R11");
        step();
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // Monitor: compare each expectation in its own cycle.
    always @(negedge clk) begin
        while (!done && q.size() > 0 && q[0].at <= cyc) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (e.at != cyc) begin
                n_fail++;
                $display("FAIL %s missed cycle act=%0d exp=%0d", e.rq, cyc, e.at);
            end else if (oe !== e.oe) begin
                n_fail++;
                $display("FAIL %s oe act=%h exp=%h", e.rq, oe, e.oe);
            end else if (e.chk_pins && pins !== e.pins) begin
                n_fail++;
                $display("FAIL %s pins act=%h exp=%h", e.rq, pins, e.pins);
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        step(); step(); step();
        push(cyc, 20'h0, 20'h0, 1'b1, "R1");          // during reset
        step();
        rst_n = 1'b1;
        push(cyc + 1, 20'h0, 20'h0, 1'b1, "R1");      // after reset, before a line
        step(); step();

        // R3, R8: 20-bit two-lane, Cb/Cr alternation
        new_line(3, "R2");
        pix(10'h2A5, 10'h155, 10'h3C3, "R3");
        mode_req = 3'd0;                               // no strobe: ignored (R2)
        push(cyc + 1, 20'h0, bmask(3), 1'b0, "R2");
        pix(10'h0F0, 10'h111, 10'h2EE, "R8");
        pix(10'h3FF, 10'h001, 10'h200, "R8");
        step();
        new_line(3, "R2");
        pix(10'h123, 10'h0AB, 10'h3CD, "R8");          // restarts on Cb
        step();

        // R4: 16-bit two-lane truncation
        new_line(2, "R2");
        pix(10'h3FF, 10'h2D7, 10'h1E9, "R4");
        pix(10'h1A3, 10'h2D7, 10'h1E9, "R4");
        step();

        // R5, R7: 8-bit interleaved
        new_line(0, "R2");
        pix(10'h2C1, 10'h3B7, 10'h04E, "R5");
        pix(10'h19D, 10'h3B7, 10'h04E, "R5");
        pix(10'h0FF, 10'h1C0, 10'h233, "R7");

        // R6, R7: 10-bit interleaved
        new_line(1, "R2");
        pix(10'h2C1, 10'h3B7, 10'h04E, "R6");
        pix(10'h19D, 10'h3B5, 10'h04F, "R6");
        step();

        // R9..R11: DDR RGB
        new_line(4, "R2");
        ddr_pix(10'h2B6, 10'h3C9, 10'h15A);
        ddr_pix(10'h0E1, 10'h07F, 10'h3A4);

        // R12: unused codes
        new_line(5, "R12");
        step();
        new_line(7, "R12");
        step();
        new_line(6, "R12");
        step(); step(); step();

        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R1 pending expectations act=%0d exp=0", q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule